// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss for a 32-bit address space by searching a hashed page table in memory. A request carries the effective address and the fetch/data kind. It also carries the 24-bit virtual segment identifier and the no-execute flag of the segment register that covers the address, which the surrounding logic selects by EA bits 31..28. The table base and the table-size field come from the storage description register. The walker reads table words one at a time over a request/ready port.

The search first scans the eight entries of the primary group, then the eight entries of the secondary group, whose hash is the bitwise complement of the primary hash. A matching entry causes a read of its second word. If the referenced bit in that word is clear, the walker writes the word back with the bit set. It then reports a refill record made of the real page number, the protection bits, the changed bit and the address of the second word. When no entry matches in either group, it reports a hash-table-miss fault. An instruction fetch through a no-execute segment is refused with a protection fault before any memory access.

The controller has five states. ST_IDLE waits for start. It goes to ST_REPORT on a refused fetch, and to ST_PROBE otherwise. ST_PROBE reads first words. On a match it goes to ST_LOAD_W1. After the last slot of the secondary group it goes to ST_REPORT. After the last slot of the primary group it re-enters ST_PROBE on the secondary group, and otherwise it re-enters ST_PROBE on the next slot. ST_LOAD_W1 reads the second word and goes to ST_MARK_REF if the referenced bit is clear, or to ST_REPORT if it is set. ST_MARK_REF performs the write-back and then goes to ST_REPORT. ST_REPORT pulses done for one cycle and returns to ST_IDLE.

Top module: `hpw_walker`

## Requirements
- R1: During and right after reset, busy, done and mem_req are low.
- R2: The group address is {tbl_base,16'h0} ORed with (hash << 6) masked by {7'b0, tbl_size, ten ones, six zeros}. The primary hash is seg_vsid[18:0] XOR {3'b0, req_ea[27:12]}. Entry n of a group sits at group + 8*n, with its first word at offset 0 and its second word at offset 4. All addresses are word aligned.
- R3: The eight primary slots are read in ascending order first. Only if none matches are the eight secondary slots read, using the one's complement of the primary hash.
- R4: A first word matches only when bit 31 (valid) is 1, bits 30..7 equal seg_vsid, bit 6 equals the pass (0 primary, 1 secondary), and bits 5..0 equal req_ea[27:22].
- R5: On a match, done comes with hit=1 and fault=0 (none). res_rpn is second-word bits 31..12, res_pp is bits 1..0, res_chg is bit 7, and res_pte1_addr is the second-word address.
- R6: When second-word bit 8 (referenced) is clear, exactly one write of that word with bit 8 set goes to the second-word address before done. When the bit is set, there is no write.
- R7: When neither group matches, done comes after exactly 16 first-word reads, with hit=0 and fault=1 (table miss).
- R8: With req_fetch=1 and seg_noexec=1, done comes with hit=0 and fault=2 (protection) and no memory access. With req_fetch=0 the flag has no effect.
- R9: busy is high from the accepted start until done. done is a one-cycle pulse with busy low. A start while busy is ignored, and changes to the request inputs during a walk do not affect the result.
- R10: A memory request keeps its address, write enable and write data unchanged until mem_ready is seen.
- R11: A walk makes at most 16 first-word reads, one second-word read and one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| req_ea | input | 32 | Effective address of the missed access |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| seg_vsid | input | 24 | Virtual segment identifier of the addressed segment |
| seg_noexec | input | 1 | No-execute flag of the addressed segment |
| tbl_base | input | 16 | Table base, address bits 31..16 |
| tbl_size | input | 9 | Table-size mask field, placed at address bits 24..16 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Entry found (valid with done) |
| fault | output | 2 | 0 none, 1 table miss, 2 protection |
| res_rpn | output | 20 | Real page number of the found entry |
| res_pp | output | 2 | Protection bits of the found entry |
| res_chg | output | 1 | Changed bit of the found entry |
| res_pte1_addr | output | 32 | Address of the found entry's second word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
The sharpest coincidence is a match in slot 7 of a pass. In that cycle the match decision and the end-of-group decision (switch to the secondary group, or declare a miss) resolve on the same ready edge. The bench places the only valid entry in secondary slot 7. It also puts a decoy that differs only in the pass flag into the primary group. It then requires a hit with 17 reads, where either a miss after 16 reads or an early primary hit would show the wrong decision won. A second coincidence is a start arriving in the same window as the walk's own progress. This is provoked by pulsing start, with altered inputs, partway through a stalled walk, and is judged by a single done whose record belongs to the first request.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

    localparam int ADDR_W      = 32;
    localparam int VSID_W      = 24;
    localparam int HASH_W      = 19;
    localparam int PAGE_IDX_W  = 16;
    localparam int API_W       = 6;
    localparam int BASE_W      = 16;
    localparam int SIZE_W      = 9;
    localparam int RPN_W       = 20;
    localparam int PP_W        = 2;
    localparam int GROUP_SLOTS = 8;
    localparam int ENTRY_BYTES = 8;
    localparam int GROUP_SH    = 6;

    localparam int W0_VALID_BIT = 31;
    localparam int W0_PASS_BIT  = 6;
    localparam int W1_REF_BIT   = 8;
    localparam int W1_CHG_BIT   = 7;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PROBE    = 3'd1,
        ST_LOAD_W1  = 3'd2,
        ST_MARK_REF = 3'd3,
        ST_REPORT   = 3'd4
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_PROT = 2'd2
    } walk_fault_t;

    typedef struct packed {
        logic [RPN_W-1:0] rpn;
        logic             refd;
        logic             chg;
        logic [PP_W-1:0]  pp;
    } pte_lo_t;

endpackage

// File: rtl/hpw_hash_gen.sv
module hpw_hash_gen
    import hpw_pkg::*;
(
    input  logic [VSID_W-1:0]     vsid,
    input  logic [PAGE_IDX_W-1:0] page_idx,
    input  logic [BASE_W-1:0]     base,
    input  logic [SIZE_W-1:0]     size_field,
    input  logic                  second_pass,
    output logic [ADDR_W-1:0]     group_addr
);
    localparam int LOW_ONES  = 16 - GROUP_SH;
    localparam int TOP_ZEROS = ADDR_W - SIZE_W - 16;
    localparam int HI_ZEROS  = ADDR_W - HASH_W - GROUP_SH;

    logic [HASH_W-1:0] primary;
    logic [HASH_W-1:0] chosen;
    logic [ADDR_W-1:0] shifted;
    logic [ADDR_W-1:0] size_mask;
    logic [VSID_W-HASH_W-1:0] unused_vsid_hi;

    assign unused_vsid_hi = vsid[VSID_W-1:HASH_W];

    always_comb begin
        primary    = vsid[HASH_W-1:0] ^ {{(HASH_W-PAGE_IDX_W){1'b0}}, page_idx};
        chosen     = second_pass ? ~primary : primary;
        shifted    = {{HI_ZEROS{1'b0}}, chosen, {GROUP_SH{1'b0}}};
        size_mask  = {{TOP_ZEROS{1'b0}}, size_field, {LOW_ONES{1'b1}}, {GROUP_SH{1'b0}}};
        group_addr = {base, {(ADDR_W-BASE_W){1'b0}}} | (shifted & size_mask);
    end
endmodule

// File: rtl/hpw_pte_match.sv
module hpw_pte_match
    import hpw_pkg::*;
(
    input  logic [ADDR_W-1:0] word0,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              second_pass,
    output logic              match
);
    logic valid_ok;
    logic pass_ok;
    logic vsid_ok;
    logic api_ok;

    always_comb begin
        valid_ok = word0[W0_VALID_BIT];
        pass_ok  = (word0[W0_PASS_BIT] == second_pass);
        vsid_ok  = (word0[W0_VALID_BIT-1:W0_PASS_BIT+1] == vsid);
        api_ok   = (word0[API_W-1:0] == api);
        match    = valid_ok && pass_ok && vsid_ok && api_ok;
    end
endmodule

// File: rtl/hpw_pte_decode.sv
module hpw_pte_decode
    import hpw_pkg::*;
(
    input  logic [ADDR_W-1:0] word1,
    output pte_lo_t           fields
);
    logic [ADDR_W-1:0] unused_w1;

    assign unused_w1 = word1;

    always_comb begin
        fields.rpn  = word1[ADDR_W-1:ADDR_W-RPN_W];
        fields.refd = word1[W1_REF_BIT];
        fields.chg  = word1[W1_CHG_BIT];
        fields.pp   = word1[PP_W-1:0];
    end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
    import hpw_pkg::*;
#(
    parameter int SLOTS     = GROUP_SLOTS,
    parameter int ENT_BYTES = ENTRY_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     req_ea,
    input  logic                  req_fetch,
    input  logic [VSID_W-1:0]     seg_vsid,
    input  logic                  seg_noexec,
    input  logic [BASE_W-1:0]     tbl_base,
    input  logic [SIZE_W-1:0]     tbl_size,
    output logic                  busy,
    output logic                  done,
    output logic                  hit,
    output logic [1:0]            fault,
    output logic [RPN_W-1:0]      res_rpn,
    output logic [PP_W-1:0]       res_pp,
    output logic                  res_chg,
    output logic [ADDR_W-1:0]     res_pte1_addr,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [ADDR_W-1:0]     mem_wdata,
    input  logic [ADDR_W-1:0]     mem_rdata,
    input  logic                  mem_ready
);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int OFS_SH   = $clog2(ENT_BYTES);
    localparam int W1_OFS   = ENT_BYTES / 2;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [ADDR_W-1:0] REF_MASK  = ADDR_W'(1) << W1_REF_BIT;

    walk_state_t state_q, state_d;

    logic [PAGE_IDX_W-1:0] page_q;
    logic [VSID_W-1:0]     vsid_q;
    logic [BASE_W-1:0]     base_q;
    logic [SIZE_W-1:0]     size_q;
    logic                  pass_q;
    logic [SLOT_W-1:0]     slot_q;
    logic [ADDR_W-1:0]     w1_q;

    logic                  hit_q;
    walk_fault_t           fault_q;
    logic [RPN_W-1:0]      rpn_q;
    logic [PP_W-1:0]       pp_q;
    logic                  chg_q;
    logic [ADDR_W-1:0]     pte1_q;

    logic [ADDR_W-1:0]     group_addr;
    logic [ADDR_W-1:0]     entry_addr;
    logic [ADDR_W-1:0]     w1_addr;
    logic                  slot_match;
    pte_lo_t               w1_fields;
    logic                  refuse_fetch;
    logic                  last_slot;
    logic [11:0]           unused_ea_bits;

    assign unused_ea_bits = {req_ea[ADDR_W-1:28], req_ea[11:4]} ^ {8'h00, req_ea[3:0]};

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    hpw_hash_gen u_hash (
        .vsid        (vsid_q),
        .page_idx    (page_q),
        .base        (base_q),
        .size_field  (size_q),
        .second_pass (pass_q),
        .group_addr  (group_addr)
    );

    hpw_pte_match u_match (
        .word0       (mem_rdata),
        .vsid        (vsid_q),
        .api         (page_q[PAGE_IDX_W-1:PAGE_IDX_W-API_W]),
        .second_pass (pass_q),
        .match       (slot_match)
    );

    hpw_pte_decode u_decode (
        .word1  (mem_rdata),
        .fields (w1_fields)
    );

    always_comb begin
        entry_addr   = group_addr | (ADDR_W'(slot_q) << OFS_SH);
        w1_addr      = entry_addr | ADDR_W'(W1_OFS);
        refuse_fetch = req_fetch && seg_noexec;
        last_slot    = (slot_q == LAST_SLOT);
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Transitions
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = refuse_fetch ? ST_REPORT : ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (mem_ready) begin
                    if (slot_match) begin
                        state_d = ST_LOAD_W1;
                    end else if (last_slot && pass_q) begin
                        state_d = ST_REPORT;
                    end
                end
            end
            ST_LOAD_W1: begin
                if (mem_ready) begin
                    state_d = w1_fields.refd ? ST_REPORT : ST_MARK_REF;
                end
            end
            ST_MARK_REF: begin
                if (mem_ready) begin
                    state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Walk context and result record
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            vsid_q  <= '0;
            base_q  <= '0;
            size_q  <= '0;
            pass_q  <= 1'b0;
            slot_q  <= '0;
            w1_q    <= '0;
            hit_q   <= 1'b0;
            fault_q <= FLT_NONE;
            rpn_q   <= '0;
            pp_q    <= '0;
            chg_q   <= 1'b0;
            pte1_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        page_q <= req_ea[27:12];
                        vsid_q <= seg_vsid;
                        base_q <= tbl_base;
                        size_q <= tbl_size;
                        pass_q <= 1'b0;
                        slot_q <= '0;
                        if (refuse_fetch) begin
                            hit_q   <= 1'b0;
                            fault_q <= FLT_PROT;
                            rpn_q   <= '0;
                            pp_q    <= '0;
                            chg_q   <= 1'b0;
                            pte1_q  <= '0;
                        end
                    end
                end
                ST_PROBE: begin
                    if (mem_ready && !slot_match) begin
                        if (last_slot) begin
                            if (pass_q) begin
                                hit_q   <= 1'b0;
                                fault_q <= FLT_MISS;
                                rpn_q   <= '0;
                                pp_q    <= '0;
                                chg_q   <= 1'b0;
                                pte1_q  <= '0;
                            end else begin
                                pass_q <= 1'b1;
                                slot_q <= '0;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_LOAD_W1: begin
                    if (mem_ready) begin
                        w1_q    <= mem_rdata;
                        hit_q   <= 1'b1;
                        fault_q <= FLT_NONE;
                        rpn_q   <= w1_fields.rpn;
                        pp_q    <= w1_fields.pp;
                        chg_q   <= w1_fields.chg;
                        pte1_q  <= w1_addr;
                    end
                end
                ST_MARK_REF: begin
                end
                ST_REPORT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PROBE: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = entry_addr;
            end
            ST_LOAD_W1: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = w1_addr;
            end
            ST_MARK_REF: begin
                busy      = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = w1_addr;
                mem_wdata = w1_q | REF_MASK;
            end
            ST_REPORT: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign hit           = hit_q;
    assign fault         = fault_q;
    assign res_rpn       = rpn_q;
    assign res_pp        = pp_q;
    assign res_chg       = chg_q;
    assign res_pte1_addr = pte1_q;

endmodule

// File: rtl/hpw_walker_chk.sv
module hpw_walker_chk
    import hpw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic [1:0]        fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ready
);
    localparam int MAX_ACC = 2 * GROUP_SLOTS + 2;

    int unsigned acc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= 0;
        end else if (done) begin
            acc_cnt <= 0;
        end else if (mem_req && mem_ready) begin
            acc_cnt <= acc_cnt + 1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);                                                  // R1

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));                                // R2

    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (fault == 2'd0));                                   // R5

    AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (fault != 2'd0));                                  // R7

    AST_WRITE_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[W1_REF_BIT]);                       // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));                                        // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata))); // R10

    AST_ACCESS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_cnt <= MAX_ACC);                                                  // R11

endmodule

bind hpw_walker hpw_walker_chk u_chk (.*);

// File: tb/hpw_walker_bench.sv
module hpw_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_fetch = 1'b0;
    logic [23:0] seg_vsid = '0;
    logic        seg_noexec = 1'b0;
    logic [15:0] tbl_base = '0;
    logic [8:0]  tbl_size = '0;
    logic        busy, done, hit, res_chg;
    logic [1:0]  fault, res_pp;
    logic [19:0] res_rpn;
    logic [31:0] res_pte1_addr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hpw_walker u_hpw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .req_ea(req_ea),
        .req_fetch(req_fetch), .seg_vsid(seg_vsid), .seg_noexec(seg_noexec),
        .tbl_base(tbl_base), .tbl_size(tbl_size), .busy(busy), .done(done),
        .hit(hit), .fault(fault), .res_rpn(res_rpn), .res_pp(res_pp),
        .res_chg(res_chg), .res_pte1_addr(res_pte1_addr), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int compared = 0;
    int mismatched = 0;
    int dones = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int stall = 0;
    bit finished = 1'b0;

    logic [31:0] mem [logic [31:0]];

    typedef struct {
        string       req;
        bit          hit;
        logic [1:0]  fault;
        logic [19:0] rpn;
        logic [1:0]  pp;
        bit          chg;
        logic [31:0] pte1;
        int          reads;
        int          writes;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic [31:0] ea, input logic [23:0] vsid,
                                        input logic [15:0] base, input logic [8:0] size,
                                        input bit pass);
        logic [18:0] h;
        logic [31:0] m;
        h = vsid[18:0] ^ {3'b000, ea[27:12]};
        if (pass) h = ~h;
        m = {7'b0, size, 10'h3FF, 6'b0};
        return {base, 16'h0} | ({7'b0, h, 6'b0} & m);
    endfunction

    function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] vsid,
                                          input bit pass, input logic [5:0] api);
        return {v, vsid, pass, api};
    endfunction

    function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input bit rf,
                                          input bit ch, input logic [1:0] pp);
        return {rpn, 3'b000, rf, ch, 5'b00000, pp};
    endfunction

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Reference search, built from the requirements
    function automatic exp_t model(input string req, input logic [31:0] ea, input bit fetch,
                                   input logic [23:0] vsid, input bit nx,
                                   input logic [15:0] base, input logic [8:0] size);
        exp_t e;
        e.req = req; e.hit = 0; e.fault = 2'd1; e.rpn = 0; e.pp = 0; e.chg = 0;
        e.pte1 = 0; e.reads = 0; e.writes = 0;
        if (fetch && nx) begin
            e.fault = 2'd2;
            return e;
        end
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 8; s++) begin
                logic [31:0] a;
                logic [31:0] w0;
                a  = grp(ea, vsid, base, size, p[0]) + 32'(s * 8);
                w0 = rd(a);
                e.reads++;
                if (w0[31] && w0[30:7] == vsid && w0[6] == p[0] && w0[5:0] == ea[27:22]) begin
                    logic [31:0] w1;
                    w1 = rd(a + 4);
                    e.reads++;
                    e.hit = 1; e.fault = 0; e.rpn = w1[31:12]; e.pp = w1[1:0];
                    e.chg = w1[7]; e.pte1 = a + 4; e.writes = w1[8] ? 0 : 1;
                    return e;
                end
            end
        end
        return e;
    endfunction

    // Memory responder: fixed stall per access, checks request stability
    initial begin : responder
        bit          holding = 0;
        int          cnt = 0;
        logic [31:0] last_addr = 0;
        logic [31:0] last_wdata = 0;
        bit          last_we = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) holding = 0;
            mem_ready = 1'b0;
            mem_rdata = 32'h0;
            if (rst_n && mem_req) begin
                if (holding) begin
                    chk(mem_addr == last_addr && mem_we == last_we && mem_wdata == last_wdata,
                        "R10", "request changed while stalled", mem_addr, last_addr);
                end else begin
                    holding = 1; cnt = 0;
                    last_addr = mem_addr; last_we = mem_we; last_wdata = mem_wdata;
                end
                if (cnt >= stall) begin
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = rd(mem_addr);
                        rd_cnt++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Monitor: pop and compare at each completion
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                dones++;
                if (sb.size() == 0) begin
                    chk(0, "R9", "done with no pending request", 32'(dones), 32'(dones - 1));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(hit == e.hit, e.req, "hit", 32'(hit), 32'(e.hit));
                    chk(fault == e.fault, e.req, "fault", 32'(fault), 32'(e.fault));
                    chk(busy == 1'b0, "R9", "busy with done", 32'(busy), 32'd0);
                    if (e.hit) begin
                        chk(res_rpn == e.rpn, "R5", "rpn", 32'(res_rpn), 32'(e.rpn));
                        chk(res_pp == e.pp, "R5", "pp", 32'(res_pp), 32'(e.pp));
                        chk(res_chg == e.chg, "R5", "chg", 32'(res_chg), 32'(e.chg));
                        chk(res_pte1_addr == e.pte1, "R5", "pte1 addr", res_pte1_addr, e.pte1);
                        if (e.writes == 1)
                            chk(rd(e.pte1)[8] == 1'b1, "R6", "ref bit in memory",
                                rd(e.pte1), rd(e.pte1) | 32'h100);
                    end
                    chk(rd_cnt == e.reads, "R11", "read count", 32'(rd_cnt), 32'(e.reads));
                    chk(wr_cnt == e.writes, "R6", "write count", 32'(wr_cnt), 32'(e.writes));
                end
            end
        end
    end

    // Driver: build the expected item, push it, run the walk
    task automatic run_walk(input string req, input logic [31:0] ea, input bit fetch,
                            input logic [23:0] vsid, input bit nx, input logic [15:0] base,
                            input logic [8:0] size, input int st, input bit poke);
        exp_t e;
        int target;
        e = model(req, ea, fetch, vsid, nx, base, size);
        sb.push_back(e);
        target = dones + 1;
        @(negedge clk);
        stall = st; rd_cnt = 0; wr_cnt = 0;
        req_ea = ea; req_fetch = fetch; seg_vsid = vsid; seg_noexec = nx;
        tbl_base = base; tbl_size = size; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (fetch && nx) begin
            chk(done == 1'b1 && busy == 1'b0, "R8", "refused fetch reports at once",
                {30'b0, busy, done}, 32'd1);
        end else begin
            chk(busy == 1'b1, "R9", "busy after accepted start", 32'(busy), 32'd1);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            req_ea = ~ea; seg_vsid = ~vsid; tbl_base = ~base; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones < target) @(negedge clk);
        repeat (poke ? 20 : 2) @(negedge clk);
        chk(dones == target, "R9", "completions per walk", 32'(dones), 32'(target));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL R9 watchdog expired: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] ea;
        logic [23:0] vs;
        logic [15:0] bs;
        logic [31:0] g;
        bs = 16'h0010;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "reset quiet",
            {29'b0, busy, done, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "quiet after reset",
            {29'b0, busy, done, mem_req}, 32'd0);

        // R2: primary slot 0, referenced clear, no stall
        ea = 32'h1234_5678; vs = 24'hA5_1234;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g]     = mk_w0(1, vs, 0, ea[27:22]);
        mem[g + 4] = mk_w1(20'hABCDE, 0, 1, 2'b10);
        run_walk("R2", ea, 0, vs, 0, bs, 9'h000, 0, 0);
        mem.delete();

        // R4: decoys in slots 0..4, hit in slot 5 with referenced set
        ea = 32'h0FF0_3000; vs = 24'h00_0F0F;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g]      = mk_w0(0, vs, 0, ea[27:22]);
        mem[g + 8]  = mk_w0(1, vs, 0, ea[27:22] ^ 6'h01);
        mem[g + 16] = mk_w0(1, vs ^ 24'h800000, 0, ea[27:22]);
        mem[g + 24] = mk_w0(1, vs, 1, ea[27:22]);
        mem[g + 32] = mk_w0(1, vs ^ 24'h000001, 0, ea[27:22]);
        mem[g + 40] = mk_w0(1, vs, 0, ea[27:22]);
        mem[g + 44] = mk_w1(20'h00042, 1, 0, 2'b01);
        run_walk("R4", ea, 0, vs, 0, bs, 9'h000, 2, 0);
        mem.delete();

        // R3: only secondary slot 7 matches; primary holds a pass-flag decoy
        ea = 32'h3456_7000; vs = 24'h12_3456;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g + 56] = mk_w0(1, vs, 1, ea[27:22]);
        mem[g + 60] = mk_w1(20'h11111, 1, 1, 2'b11);
        g = grp(ea, vs, bs, 9'h000, 1);
        mem[g + 56] = mk_w0(1, vs, 1, ea[27:22]);
        mem[g + 60] = mk_w1(20'h5A5A5, 0, 0, 2'b00);
        run_walk("R3", ea, 0, vs, 0, bs, 9'h000, 1, 0);
        mem.delete();

        // R7: no match anywhere (secondary-flag entry placed in primary only)
        ea = 32'h0ABC_D000; vs = 24'h77_0011;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g + 8] = mk_w0(1, vs, 1, ea[27:22]);
        run_walk("R7", ea, 0, vs, 0, bs, 9'h000, 0, 0);
        mem.delete();

        // R8: no-execute fetch refused; same segment data access walks
        ea = 32'h2000_1000; vs = 24'h00_2222;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g + 16] = mk_w0(1, vs, 0, ea[27:22]);
        mem[g + 20] = mk_w1(20'h0BEEF, 0, 0, 2'b01);
        run_walk("R8", ea, 1, vs, 1, bs, 9'h000, 0, 0);
        chk(rd_cnt == 0 && wr_cnt == 0, "R8", "no memory access on refusal",
            32'(rd_cnt + wr_cnt), 32'd0);
        run_walk("R8", ea, 0, vs, 1, bs, 9'h000, 1, 0);
        mem[g + 20] = mk_w1(20'h0BEEF, 1, 0, 2'b01);
        run_walk("R8", ea, 1, vs, 0, bs, 9'h000, 0, 0);
        mem.delete();

        // R2: size field widens the hash bits used in the group address
        ea = 32'h0FFF_F000; vs = 24'hF0_0000;
        g = grp(ea, vs, 16'h0200, 9'h1FF, 0);
        chk(g[24:16] != 9'h000, "R2", "size mask exposes high hash bits", g, g | 32'h10000);
        mem[g + 24] = mk_w0(1, vs, 0, ea[27:22]);
        mem[g + 28] = mk_w1(20'hFEDCB, 0, 1, 2'b11);
        run_walk("R2", ea, 0, vs, 0, 16'h0200, 9'h1FF, 0, 0);
        mem.delete();

        // R9: start and changed inputs during a stalled walk are ignored
        ea = 32'h0555_5000; vs = 24'h01_5555;
        g = grp(ea, vs, bs, 9'h000, 0);
        mem[g + 24] = mk_w0(1, vs, 0, ea[27:22]);
        mem[g + 28] = mk_w1(20'h33333, 0, 0, 2'b10);
        run_walk("R9", ea, 0, vs, 0, bs, 9'h000, 3, 1);
        mem.delete();

        chk(sb.size() == 0, "R9", "scoreboard drained", 32'(sb.size()), 32'd0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule